// File: doc/BRIEF.md
# Flash Rewrite Mode Control Register

This block is a small bus-mapped control unit that lets a CPU reprogram its own on-chip flash under guard. It sits between a simple register write/read port and the flash controller. It holds a rewrite-mode select bit, a whole-user-area erase/write enable and a small-block erase/write enable. It also has a flash-reset pulse bit. The select bit and the small-block enable can only be turned on by an unlock pair of writes to the same register. The flash reset can only be fired by a matching pair.

While rewrite mode is on, the block tells the interrupt controller to hold off interrupts. While the flash reports a program or erase in progress, it keeps the watchdog cleared.

Clearing bits is cheap, but it is guarded. A clear attempted during a busy flash operation is dropped. Leaving rewrite mode while any block enable is still on is also dropped. Either case raises a sticky error flag. A synchronous active-high reset returns everything to zero.

Register map:
- Address 0 is the mode register. Bit 0 is the select bit and bit 1 is the flash-reset bit. On read, bit 2 shows busy and bit 3 shows error.
- Address 1 is the enable register. Bit 0 is the whole-area enable and bit 1 is the small-block enable.

Top module: `frw_ctrl`

## Requirements
- R1: A cycle with `rst` high clears every output and every register bit, whatever mode was active. After reset, both registers read back 0.
- R2: The select bit (address 0, bit 0) becomes 1 only when a write of 1 to it directly follows a write of 0 to it, counting only writes to address 0. A lone write of 1 is ignored.
- R3: Unlock tracking is kept per register. Writes to address 1 do not break an address-0 sequence. Two writes of 1 in a row do not unlock.
- R4: The whole-area enable (address 1, bit 0) is set by a plain write of 1, but only while rewrite mode is active. Otherwise the write has no effect.
- R5: The small-block enable (address 1, bit 1) is set only by a write of 0 then a write of 1 to that bit, in consecutive writes to address 1, while rewrite mode is active.
- R6: A write with address 0 bit 1 = 1, directly followed by an address-0 write with bit 1 = 0, produces `flash_rst_pulse` high for exactly the one cycle after that second write's clock edge.
- R7: `irq_inhibit` is high exactly while `rw_active` is high.
- R8: `wdt_clear` is high in the cycle after any cycle in which `flash_busy` and rewrite mode are both high, and low otherwise.
- R9: Writing 0 to the select bit or to either enable bit clears it on the next edge, with no sequence, when the clear is allowed.
- R10: A clear of the select bit or of an enable bit attempted while `flash_busy` is high is ignored and sets `seq_err`. `seq_err` stays set until reset.
- R11: Writing 0 to the select bit while either block enable is set is ignored and sets `seq_err`.
- R12: `bus_rdata` is registered and shows the addressed register one cycle after `bus_addr`:
  - address 0 gives bit 0 select, bit 1 reads 0, bit 2 `flash_busy`, bit 3 `seq_err`;
  - address 1 gives bit 0 whole-area enable, bit 1 small-block enable;
  - all other bits and addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| flash_busy | input | 1 | Flash program/erase in progress |
| rw_active | output | 1 | Rewrite mode select bit |
| irq_inhibit | output | 1 | Interrupt hold-off |
| all_blk_en | output | 1 | Whole-user-area erase/write enable |
| small_blk_en | output | 1 | Small-block erase/write enable |
| flash_rst_pulse | output | 1 | One-cycle flash reset |
| wdt_clear | output | 1 | Watchdog clear request |
| seq_err | output | 1 | Sticky guard-violation flag |

## Verification
Some properties are checked by assertions on every cycle:
- the select bit only rises right after an address-0 write carrying a 1;
- the reset pulse is one cycle wide and follows a 0 write;
- the watchdog clear follows busy in rewrite mode;
- the select bit cannot drop while busy;
- the error flag never falls;
- rewrite mode never ends with an enable still on.

Other behaviour needs the bench's scenarios:
- whether a sequence really requires the exact 0-then-1 pairing per register;
- whether lone or repeated 1s are ignored;
- whether enables are refused outside rewrite mode;
- the readback layout.

// File: rtl/frw_pkg.sv
package frw_pkg;
  // register addresses
  localparam int MODE_ADDR = 0;
  localparam int ENAB_ADDR = 1;
  // mode register bit positions
  localparam int SEL_BIT   = 0;
  localparam int FRST_BIT  = 1;
  localparam int BUSY_BIT  = 2;
  localparam int ERR_BIT   = 3;
  // enable register bit positions
  localparam int ALL_BIT   = 0;
  localparam int SMALL_BIT = 1;
  // unlock detector slots
  localparam int NUM_SEQ   = 3;
  localparam int SEQ_SEL   = 0;
  localparam int SEQ_SMALL = 1;
  localparam int SEQ_FRST  = 2;
endpackage

// File: rtl/frw_seq_det.sv
// Two-write unlock detector for one bit of one register.
module frw_seq_det #(
  parameter bit FIRST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic bit_val,
  output logic fire
);
  localparam bit SECOND_VAL = ~FIRST_VAL;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b0;
    else if (wr_hit) armed_q <= (bit_val == FIRST_VAL);
  end

  assign fire = wr_hit && armed_q && (bit_val == SECOND_VAL);
endmodule

// File: rtl/frw_rdback.sv
// Registered readback mux.
module frw_rdback
  import frw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel,
  input  logic              busy,
  input  logic              err,
  input  logic              all_en,
  input  logic              small_en,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mode_word, enab_word, next_word;

  always_comb begin
    mode_word           = '0;
    mode_word[SEL_BIT]  = sel;
    mode_word[BUSY_BIT] = busy;
    mode_word[ERR_BIT]  = err;
    enab_word            = '0;
    enab_word[ALL_BIT]   = all_en;
    enab_word[SMALL_BIT] = small_en;
    if (addr == ADDR_W'(MODE_ADDR))      next_word = mode_word;
    else if (addr == ADDR_W'(ENAB_ADDR)) next_word = enab_word;
    else                                 next_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= next_word;
  end
endmodule

// File: rtl/frw_ctrl.sv
module frw_ctrl
  import frw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flash_busy,
  output logic              rw_active,
  output logic              irq_inhibit,
  output logic              all_blk_en,
  output logic              small_blk_en,
  output logic              flash_rst_pulse,
  output logic              wdt_clear,
  output logic              seq_err
);
  localparam logic [NUM_SEQ-1:0] FIRST_VALS = 3'b100; // reset pulse arms on 1

  logic wr_mode, wr_enab;
  logic [NUM_SEQ-1:0] seq_hit, seq_bit, seq_fire;
  logic sel_q, all_q, small_q, pulse_q, wdt_q, err_q;
  logic sel_d, all_d, small_d, err_d;
  logic clr_sel, clr_all, clr_small, sel_blocked;

  assign wr_mode = bus_we && (bus_addr == ADDR_W'(MODE_ADDR));
  assign wr_enab = bus_we && (bus_addr == ADDR_W'(ENAB_ADDR));

  assign seq_hit[SEQ_SEL]   = wr_mode;
  assign seq_bit[SEQ_SEL]   = bus_wdata[SEL_BIT];
  assign seq_hit[SEQ_SMALL] = wr_enab;
  assign seq_bit[SEQ_SMALL] = bus_wdata[SMALL_BIT];
  assign seq_hit[SEQ_FRST]  = wr_mode;
  assign seq_bit[SEQ_FRST]  = bus_wdata[FRST_BIT];

  for (genvar i = 0; i < NUM_SEQ; i++) begin : g_seq
    frw_seq_det #(.FIRST_VAL(FIRST_VALS[i])) u_det (
      .clk(clk), .rst(rst), .wr_hit(seq_hit[i]),
      .bit_val(seq_bit[i]), .fire(seq_fire[i])
    );
  end

  // clear requests and their guards
  assign clr_sel     = wr_mode && !bus_wdata[SEL_BIT] && sel_q;
  assign clr_all     = wr_enab && !bus_wdata[ALL_BIT] && all_q;
  assign clr_small   = wr_enab && !bus_wdata[SMALL_BIT] && small_q;
  assign sel_blocked = flash_busy || all_q || small_q;

  always_comb begin
    sel_d = sel_q;
    if (clr_sel && !sel_blocked)  sel_d = 1'b0;
    else if (seq_fire[SEQ_SEL])   sel_d = 1'b1;

    all_d = all_q;
    if (clr_all && !flash_busy)                             all_d = 1'b0;
    else if (wr_enab && bus_wdata[ALL_BIT] && sel_q)        all_d = 1'b1;

    small_d = small_q;
    if (clr_small && !flash_busy)                 small_d = 1'b0;
    else if (seq_fire[SEQ_SMALL] && sel_q)        small_d = 1'b1;

    err_d = err_q
          | (clr_sel && sel_blocked)
          | ((clr_all || clr_small) && flash_busy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      all_q   <= 1'b0;
      small_q <= 1'b0;
      pulse_q <= 1'b0;
      wdt_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      all_q   <= all_d;
      small_q <= small_d;
      pulse_q <= seq_fire[SEQ_FRST];
      wdt_q   <= flash_busy && sel_q;
      err_q   <= err_d;
    end
  end

  frw_rdback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .sel(sel_q), .busy(flash_busy),
    .err(err_q), .all_en(all_q), .small_en(small_q), .rdata(bus_rdata)
  );

  assign rw_active       = sel_q;
  assign irq_inhibit     = sel_q;
  assign all_blk_en      = all_q;
  assign small_blk_en    = small_q;
  assign flash_rst_pulse = pulse_q;
  assign wdt_clear       = wdt_q;
  assign seq_err         = err_q;

  // R2
  sel_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rw_active) |-> $past(wr_mode && bus_wdata[SEL_BIT]));
  // R6
  rst_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    flash_rst_pulse |=> !flash_rst_pulse);
  // R6
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    flash_rst_pulse |-> $past(wr_mode && !bus_wdata[FRST_BIT]));
  // R8
  wdt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_busy && rw_active) |=> wdt_clear);
  // R10
  busy_keep_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_busy && rw_active) |=> rw_active);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);
  // R11
  exit_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rw_active) |-> $past(!all_blk_en && !small_blk_en));
  // R4
  en_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(all_blk_en) |-> $past(rw_active));
endmodule

// File: tb/frw_ctrl_test.sv
module frw_ctrl_test;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int NVEC = 13;
  // {we, addr[1:0], wdata[7:0], busy, exp sel, all, small, pulse, err}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 8'h01, 1'b0, 5'b00000}, // R2 lone 1 ignored
    {1'b1, 2'd0, 8'h00, 1'b0, 5'b00000},
    {1'b1, 2'd0, 8'h01, 1'b0, 5'b10000}, // R2 0 then 1 unlocks
    {1'b1, 2'd1, 8'h03, 1'b0, 5'b11000}, // R4 set; R5 not armed
    {1'b1, 2'd1, 8'h01, 1'b0, 5'b11000},
    {1'b1, 2'd1, 8'h03, 1'b0, 5'b11100}, // R5 small unlocked
    {1'b1, 2'd0, 8'h00, 1'b0, 5'b11101}, // R11 exit refused
    {1'b1, 2'd0, 8'h03, 1'b0, 5'b11101},
    {1'b1, 2'd0, 8'h01, 1'b0, 5'b11111}, // R6 pulse
    {1'b0, 2'd0, 8'h00, 1'b0, 5'b11101}, // R6 one cycle only
    {1'b1, 2'd1, 8'h00, 1'b0, 5'b10001}, // R9 enables cleared
    {1'b1, 2'd0, 8'h00, 1'b0, 5'b00001}, // R9 mode cleared
    {1'b1, 2'd1, 8'h03, 1'b0, 5'b00001}  // R4 ignored outside mode
  };

  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0, flash_busy = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  logic rw_active, irq_inhibit, all_blk_en, small_blk_en;
  logic flash_rst_pulse, wdt_clear, seq_err;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frw_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_busy(flash_busy),
    .rw_active(rw_active), .irq_inhibit(irq_inhibit), .all_blk_en(all_blk_en),
    .small_blk_en(small_blk_en), .flash_rst_pulse(flash_rst_pulse),
    .wdt_clear(wdt_clear), .seq_err(seq_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // outputs packed {sel, all, small, pulse, err, irq, wdt}
  function automatic logic [7:0] outs();
    return {1'b0, rw_active, all_blk_en, small_blk_en, flash_rst_pulse,
            seq_err, irq_inhibit, wdt_clear};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bus_we = 1'b0; flash_busy = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); bus_addr = ADDR_W'(a);
    @(negedge clk); d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rv;
    do_reset();
    // R1 reset state
    chk("R1 outputs after reset", outs(), 8'h00);
    rd(0, rv); chk("R1 mode readback", rv, 8'h00);
    rd(1, rv); chk("R1 enable readback", rv, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] v;
      v = VEC[i];
      @(negedge clk);
      bus_we = v[16]; bus_addr = v[15:14]; bus_wdata = v[13:6]; flash_busy = v[5];
      @(negedge clk);
      bus_we = 1'b0;
      // R7: irq follows sel; wdt low since busy low
      chk($sformatf("table vector %0d", i), outs(),
          {1'b0, v[4:0], v[4], 1'b0});
    end

    // R3 write to other register does not break the sequence
    do_reset();
    wr(0, 8'h00); wr(1, 8'h00); wr(0, 8'h01);
    chk("R3 cross-register write keeps arm", {7'd0, rw_active}, 8'h01);
    // R3 two writes of 1 do not unlock
    do_reset();
    wr(0, 8'h01); wr(0, 8'h01);
    chk("R3 repeated 1 ignored", {7'd0, rw_active}, 8'h00);

    // R12 readback layout
    wr(0, 8'h00); wr(0, 8'h01); wr(1, 8'h01);
    rd(1, rv); chk("R12 enable readback", rv, 8'h01);
    rd(3, rv); chk("R12 unmapped readback", rv, 8'h00);

    // R8 / R7 busy in rewrite mode
    @(negedge clk); flash_busy = 1'b1;
    @(negedge clk);
    chk("R8 wdt_clear while busy", {6'd0, wdt_clear, irq_inhibit}, 8'h03);
    // R10 clear while busy ignored, error raised
    wr(1, 8'h00);
    chk("R10 clear during busy", {6'd0, all_blk_en, seq_err}, 8'h03);
    rd(0, rv); chk("R12 mode readback busy+err", rv, 8'h0D);
    @(negedge clk); flash_busy = 1'b0;
    @(negedge clk);
    chk("R8 wdt_clear drops", {7'd0, wdt_clear}, 8'h00);

    // R1 reset mid-mode
    do_reset();
    chk("R1 reset clears active mode", outs(), 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule